// File: doc/BRIEF.md
# Flash Protected-Range Checker

This block sits between a host-side request path and a serial-flash cycle engine and decides, one request at a time, whether a read, a write or an erase may proceed. It holds a small bank of range words, each describing a 4 KB-aligned address window together with two independent enables: one that blocks reads inside the window and one that blocks writes and erases inside it. A request that falls in an enabled window of the matching kind is refused and an access-error pulse is raised. A request that passes is forwarded, with its type, start address and byte count, as a one-cycle start strobe to the cycle engine.

Range words are loaded through a simple indexed write port. A lock input, once seen, freezes the whole bank until the next reset, so configuration set up early cannot be undone by later software. Each range word is 32 bits: a 15-bit starting page in bits [14:0], the read enable in bit 15, a 15-bit ending page in bits [30:16] and the write enable in bit 31. Pages are 4 KB, so the window covers byte addresses from the starting page times 4096 up to and including the last byte of the ending page.

Top module: `fprg_guard`

## Requirements
- R1: While rst_n is low at a clock edge, cyc_go_o and acc_err_o are 0 after that edge; after reset all range words are 0, so every request is granted and the lock is clear.
- R2: A write with cfg_we_i=1 and cfg_idx_i in 0..4 loads cfg_wdata_i into that range word; the layout is start page [14:0], read enable bit 15, end page [30:16], write enable bit 31, and the new word governs requests sampled from the next edge on.
- R3: A range covers byte addresses start_page*4096 through end_page*4096+4095, both bounds inclusive; address bits [26:12] are compared against the page fields.
- R4: A range whose end page is below its start page covers no address, whatever its enables.
- R5: req_kind_i encodes 2'b00 read, 2'b10 write, 2'b11 erase, with 2'b01 treated as a read; a write or erase is refused if its address lies in any range with bit 31 set, and a read is refused if it lies in any range with bit 15 set.
- R6: One edge after a request is sampled, exactly one of cyc_go_o (granted) and acc_err_o (refused) is 1, for one cycle only; with no request both stay 0.
- R7: With a grant, cyc_kind_o, cyc_addr_o and cyc_len_o carry the request's type, address and byte count in the same cycle as cyc_go_o.
- R8: Only the starting address is checked; a multi-byte request that begins outside every enabled range is granted even if its later bytes fall inside one.
- R9: Once lock_i is 1 at an edge, configuration writes at that edge and at every later edge are ignored until reset.
- R10: When a configuration write and a request are sampled at the same edge, the request is judged against the range words as they were before that write.
- R11: A configuration write with cfg_idx_i of 5, 6 or 7 changes no range word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Range-word write strobe |
| cfg_idx_i | input | 3 | Range-word index |
| cfg_wdata_i | input | 32 | Range-word write data |
| lock_i | input | 1 | Freezes all range words until reset |
| req_valid_i | input | 1 | Access request strobe |
| req_kind_i | input | 2 | Access type: 00 read, 10 write, 11 erase, 01 read |
| req_addr_i | input | 27 | Starting byte address |
| req_len_i | input | 6 | Byte count minus one |
| cyc_go_o | output | 1 | One-cycle start strobe for a granted access |
| cyc_kind_o | output | 2 | Type of the granted access |
| cyc_addr_o | output | 27 | Address of the granted access |
| cyc_len_o | output | 6 | Byte count minus one of the granted access |
| acc_err_o | output | 1 | One-cycle pulse for a refused access |

## Verification
Two functions can meet at one edge: a range-word update and an access check, and likewise a range-word update and the lock taking hold. Directed steps present a write that clears a protecting range together with a request inside it, expecting a refusal judged on the old word and a grant on the following request, and present a write together with the first lock pulse, expecting the write to be dropped. The random phase mixes configuration writes, including out-of-range indices, with requests on almost every cycle, and each outcome is compared with a bench model that applies writes only after judging the request of the same edge.

// File: rtl/fprg_pkg.sv
`timescale 1ns/1ps
// fprg_pkg: shared types and helpers for the flash protected-range checker.
// Assumes the access-type code of the request port is two bits wide.
package fprg_pkg;

    // Access type carried on the request and forwarded with a grant.
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_RSVD  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_ERASE = 2'b11
    } acc_kind_e;

    // True for the access types that change flash contents.
    function automatic logic acc_modifies(input logic [1:0] kind);
        return kind[1];
    endfunction

endpackage

// File: rtl/fprg_lock.sv
`timescale 1ns/1ps
// fprg_lock: sticky configuration lock.
// Holds a flag that sets on the first edge with lock_i high and clears only
// on reset. Gates the configuration write strobe so that a write arriving
// together with the first lock pulse is already refused.
module fprg_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_i,
    input  logic cfg_we_i,
    output logic lock_q,
    output logic wr_ok
);

    // Sets on lock_i, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (lock_i) begin
            lock_q <= 1'b1;
        end
    end

    // Writes pass only while neither the stored nor the incoming lock is set.
    always_comb begin
        wr_ok = cfg_we_i && !lock_i && !lock_q;
    end

endmodule

// File: rtl/fprg_slot.sv
`timescale 1ns/1ps
// fprg_slot: one protected-range word and its address comparison.
// Stores the word for index SLOT_ID and reports, combinationally, whether
// the request page lies inside the window with the read or write enable set.
// Assumes the word layout: start page in the low field, read enable above
// it, end page in the next field, write enable at the top bit.
module fprg_slot #(
    parameter int FIELD_W = 15,
    parameter int IDX_W   = 3,
    parameter int SLOT_ID = 0,
    localparam int WORD_W = 2 * FIELD_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [FIELD_W-1:0] req_page,
    output logic [WORD_W-1:0]  word_q,
    output logic               hit_rd,
    output logic               hit_wr
);

    localparam int RPE_BIT = FIELD_W;
    localparam int LIM_LO  = FIELD_W + 1;
    localparam int WPE_BIT = WORD_W - 1;

    logic [FIELD_W-1:0] start_pg;
    logic [FIELD_W-1:0] end_pg;
    logic               in_win;

    // Loads the word when the gated strobe addresses this slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en && (wr_idx == IDX_W'(SLOT_ID))) begin
            word_q <= wr_data;
        end
    end

    // Splits the word into its page bounds.
    always_comb begin
        start_pg = word_q[FIELD_W-1:0];
        end_pg   = word_q[LIM_LO +: FIELD_W];
    end

    // Inclusive window test; an inverted window matches nothing.
    always_comb begin
        in_win = (req_page >= start_pg) && (req_page <= end_pg);
        hit_rd = in_win && word_q[RPE_BIT];
        hit_wr = in_win && word_q[WPE_BIT];
    end

endmodule

// File: rtl/fprg_verdict.sv
`timescale 1ns/1ps
// fprg_verdict: turns the per-range hits into a registered grant or refusal.
// Picks the write hits for modifying accesses and the read hits otherwise,
// then registers a one-cycle start strobe with the forwarded request fields,
// or a one-cycle access-error pulse.
module fprg_verdict
    import fprg_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int ADDR_W     = 27,
    parameter int LEN_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_kind,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic [NUM_RANGES-1:0] hit_rd_vec,
    input  logic [NUM_RANGES-1:0] hit_wr_vec,
    output logic                  go_q,
    output logic                  err_q,
    output logic [1:0]            kind_q,
    output logic [ADDR_W-1:0]     addr_q,
    output logic [LEN_W-1:0]      len_q
);

    logic blocked;

    // Selects the hit vector that matters for this access type.
    always_comb begin
        if (acc_modifies(req_kind)) begin
            blocked = |hit_wr_vec;
        end else begin
            blocked = |hit_rd_vec;
        end
    end

    // Registers the outcome strobes; both last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            go_q  <= req_valid && !blocked;
            err_q <= req_valid && blocked;
        end
    end

    // Captures the forwarded fields of a granted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= ACC_READ;
            addr_q <= '0;
            len_q  <= '0;
        end else if (req_valid && !blocked) begin
            kind_q <= req_kind;
            addr_q <= req_addr;
            len_q  <= req_len;
        end
    end

endmodule

// File: rtl/fprg_guard.sv
`timescale 1ns/1ps
// fprg_guard: flash protected-range checker, top level.
// Holds NUM_RANGES range words behind a lockable write port and judges each
// request against all of them in parallel. Only the starting address of a
// request is compared. Assumes page-granular windows of 2**PAGE_W bytes.
module fprg_guard #(
    parameter int NUM_RANGES = 5,
    parameter int FIELD_W    = 15,
    parameter int PAGE_W     = 12,
    parameter int LEN_W      = 6,
    localparam int ADDR_W    = FIELD_W + PAGE_W,
    localparam int WORD_W    = 2 * FIELD_W + 2,
    localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic [WORD_W-1:0] cfg_wdata_i,
    input  logic              lock_i,
    input  logic              req_valid_i,
    input  logic [1:0]        req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [LEN_W-1:0]  req_len_i,
    output logic              cyc_go_o,
    output logic [1:0]        cyc_kind_o,
    output logic [ADDR_W-1:0] cyc_addr_o,
    output logic [LEN_W-1:0]  cyc_len_o,
    output logic              acc_err_o
);

    logic                         lock_q;
    logic                         wr_ok;
    logic [FIELD_W-1:0]           req_page;
    logic [NUM_RANGES-1:0]        hit_rd_vec;
    logic [NUM_RANGES-1:0]        hit_wr_vec;
    logic [NUM_RANGES*WORD_W-1:0] rng_flat;

    // Page number of the starting address, the only part compared.
    always_comb begin
        req_page = req_addr_i[ADDR_W-1:PAGE_W];
    end

    fprg_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_i   (lock_i),
        .cfg_we_i (cfg_we_i),
        .lock_q   (lock_q),
        .wr_ok    (wr_ok)
    );

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_slot
        fprg_slot #(
            .FIELD_W (FIELD_W),
            .IDX_W   (IDX_W),
            .SLOT_ID (g)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_ok),
            .wr_idx   (cfg_idx_i),
            .wr_data  (cfg_wdata_i),
            .req_page (req_page),
            .word_q   (rng_flat[g*WORD_W +: WORD_W]),
            .hit_rd   (hit_rd_vec[g]),
            .hit_wr   (hit_wr_vec[g])
        );
    end

    fprg_verdict #(
        .NUM_RANGES (NUM_RANGES),
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W)
    ) u_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid_i),
        .req_kind   (req_kind_i),
        .req_addr   (req_addr_i),
        .req_len    (req_len_i),
        .hit_rd_vec (hit_rd_vec),
        .hit_wr_vec (hit_wr_vec),
        .go_q       (cyc_go_o),
        .err_q      (acc_err_o),
        .kind_q     (cyc_kind_o),
        .addr_q     (cyc_addr_o),
        .len_q      (cyc_len_o)
    );

endmodule

// File: rtl/fprg_guard_chk.sv
`timescale 1ns/1ps
// fprg_guard_chk: property checker bound to fprg_guard.
// Observes the request port, the outcome strobes, the lock flag and the
// stored range words.
module fprg_guard_chk #(
    parameter int NUM_RANGES = 5,
    parameter int FIELD_W    = 15,
    parameter int ADDR_W     = 27,
    localparam int WORD_W    = 2 * FIELD_W + 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid_i,
    input logic [ADDR_W-1:0]            req_addr_i,
    input logic                         cyc_go_o,
    input logic [ADDR_W-1:0]            cyc_addr_o,
    input logic                         acc_err_o,
    input logic                         lock_q,
    input logic [NUM_RANGES*WORD_W-1:0] rng_flat
);

    logic no_enables;

    // True when no stored word has either enable bit set.
    always_comb begin
        no_enables = 1'b1;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (rng_flat[i*WORD_W + FIELD_W] || rng_flat[i*WORD_W + WORD_W - 1]) begin
                no_enables = 1'b0;
            end
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (cyc_go_o != acc_err_o)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!cyc_go_o && !acc_err_o)); // R6
    AST_ADDR_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (!cyc_go_o || (cyc_addr_o == $past(req_addr_i)))); // R7
    AST_OPEN_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && no_enables) |=> cyc_go_o); // R5
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q); // R9
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(rng_flat)); // R9

endmodule

bind fprg_guard fprg_guard_chk #(
    .NUM_RANGES (NUM_RANGES),
    .FIELD_W    (FIELD_W),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .cyc_go_o    (cyc_go_o),
    .cyc_addr_o  (cyc_addr_o),
    .acc_err_o   (acc_err_o),
    .lock_q      (lock_q),
    .rng_flat    (rng_flat)
);

// File: tb/fprg_guard_tb.sv
`timescale 1ns/1ps
module fprg_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [2:0]  cfg_idx_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic        lock_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [1:0]  req_kind_i = '0;
    logic [26:0] req_addr_i = '0;
    logic [5:0]  req_len_i = '0;
    logic        cyc_go_o;
    logic [1:0]  cyc_kind_o;
    logic [26:0] cyc_addr_o;
    logic [5:0]  cyc_len_o;
    logic        acc_err_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] model [5];
    bit          lock_m;

    always #10 clk = ~clk;

    fprg_guard u_dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_we_i (cfg_we_i), .cfg_idx_i (cfg_idx_i), .cfg_wdata_i (cfg_wdata_i),
        .lock_i (lock_i),
        .req_valid_i (req_valid_i), .req_kind_i (req_kind_i),
        .req_addr_i (req_addr_i), .req_len_i (req_len_i),
        .cyc_go_o (cyc_go_o), .cyc_kind_o (cyc_kind_o),
        .cyc_addr_o (cyc_addr_o), .cyc_len_o (cyc_len_o),
        .acc_err_o (acc_err_o)
    );

    function automatic logic [31:0] mk(input int sp, input int ep, input bit rp, input bit wp);
        return {wp, 15'(ep), rp, 15'(sp)};
    endfunction

    function automatic bit exp_block(input logic [1:0] k, input logic [26:0] a);
        bit hit = 1'b0;
        for (int i = 0; i < 5; i++) begin
            logic [14:0] pg = a[26:12];
            bit inwin = (pg >= model[i][14:0]) && (pg <= model[i][30:16]);
            bit en = k[1] ? model[i][31] : model[i][15];
            if (inwin && en) hit = 1'b1;
        end
        return hit;
    endfunction

    task automatic check(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive, judge with old model, update model, sample after edge.
    task automatic step(input bit we, input logic [2:0] idx, input logic [31:0] wd, input bit lk,
                        input bit rv, input logic [1:0] k, input logic [26:0] a,
                        input logic [5:0] ln, input string tag);
        bit blk;
        cfg_we_i = we; cfg_idx_i = idx; cfg_wdata_i = wd; lock_i = lk;
        req_valid_i = rv; req_kind_i = k; req_addr_i = a; req_len_i = ln;
        blk = exp_block(k, a);
        if (we && !lock_m && !lk && idx < 5) model[idx] = wd;
        if (lk) lock_m = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (rv) begin
            check(tag, {cyc_go_o, acc_err_o} == {!blk, blk},
                  {62'd0, cyc_go_o, acc_err_o}, {62'd0, !blk, blk});
            if (!blk)
                check("R7", {cyc_kind_o, cyc_addr_o, cyc_len_o} == {k, a, ln},
                      {29'd0, cyc_kind_o, cyc_addr_o, cyc_len_o}, {29'd0, k, a, ln});
        end else begin
            check(tag, {cyc_go_o, acc_err_o} == 2'b00,
                  {62'd0, cyc_go_o, acc_err_o}, 64'd0);
        end
    endtask

    task automatic req(input logic [1:0] k, input logic [26:0] a, input string tag);
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b1, k, a, 6'd3, tag);
    endtask

    task automatic cfg(input logic [2:0] idx, input logic [31:0] wd, input string tag);
        step(1'b1, idx, wd, 1'b0, 1'b0, 2'b00, 27'd0, 6'd0, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid_i = 1'b1;
        cfg_we_i = 1'b0;
        lock_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", {cyc_go_o, acc_err_o} == 2'b00, {62'd0, cyc_go_o, acc_err_o}, 64'd0);
        for (int i = 0; i < 5; i++) model[i] = '0;
        lock_m = 1'b0;
        req_valid_i = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        // R1: fresh words protect nothing
        req(2'b10, 27'h0000000, "R1");
        req(2'b00, 27'h7FFF000, "R1");
        // R2/R3: write-protected window pages 0x10..0x12
        cfg(3'd0, mk(16, 18, 1'b0, 1'b1), "R2");
        req(2'b10, 27'h0010000, "R3");
        req(2'b10, 27'h0012FFF, "R3");
        req(2'b10, 27'h0013000, "R3");
        req(2'b10, 27'h000FFFF, "R3");
        req(2'b11, 27'h0011000, "R5");
        req(2'b00, 27'h0011000, "R5");
        // R5: read-protected single page 0x20
        cfg(3'd1, mk(32, 32, 1'b1, 1'b0), "R2");
        req(2'b00, 27'h0020800, "R5");
        req(2'b01, 27'h0020800, "R5");
        req(2'b10, 27'h0020800, "R5");
        // R4: inverted window with both enables
        cfg(3'd2, mk(64, 48, 1'b1, 1'b1), "R2");
        req(2'b10, 27'h0040000, "R4");
        req(2'b00, 27'h0030000, "R4");
        req(2'b11, 27'h0038000, "R4");
        // R8: start below page 0x20, 64 bytes reaching into it
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b1, 2'b00, 27'h001FFF0, 6'd63, "R8");
        // R11: out-of-range index must not clear range 1
        cfg(3'd5, 32'd0, "R11");
        cfg(3'd7, 32'd0, "R11");
        req(2'b00, 27'h0020000, "R11");
        // R10: clear range 0 while a write inside it is judged
        step(1'b1, 3'd0, 32'd0, 1'b0, 1'b1, 2'b10, 27'h0011000, 6'd3, "R10");
        req(2'b10, 27'h0011000, "R10");
        // R6: idle cycle shows no strobe
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b0, 2'b10, 27'h0011000, 6'd3, "R6");
        // random phase, unlocked
        for (int n = 0; n < 3000; n++) begin
            bit we = ($urandom % 6) == 0;
            logic [2:0] idx = 3'($urandom % 8);
            logic [31:0] wd = mk($urandom % 24, $urandom % 24, 1'($urandom), 1'($urandom));
            bit rv = ($urandom % 4) != 0;
            logic [26:0] a = {15'($urandom % 26), 12'($urandom % 4096)};
            step(we, idx, wd, 1'b0, rv, 2'($urandom % 4), a, 6'($urandom % 64), "R5");
        end
        // R9: lock arrives with a write; both the write and later ones dropped
        for (int i = 0; i < 5; i++) cfg(3'(i), 32'd0, "R2");
        step(1'b1, 3'd0, mk(0, 100, 1'b1, 1'b1), 1'b1, 1'b1, 2'b10, 27'h0005000, 6'd0, "R9");
        req(2'b10, 27'h0005000, "R9");
        cfg(3'd3, mk(0, 100, 1'b1, 1'b1), "R9");
        req(2'b00, 27'h0005000, "R9");
        // R9: reset releases the lock
        do_reset();
        cfg(3'd3, mk(0, 100, 1'b1, 1'b1), "R9");
        req(2'b00, 27'h0005000, "R9");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule